// File: doc/BRIEF.md
# IF Input Capture and Gain Shifter

This block is the first stage of a digital downconverter datapath. It takes a 14-bit sampled IF word on each clock edge where the active-low enable is held low, normalises it to two's complement (the input may arrive either as two's complement or as offset binary, chosen by a static configuration bit), and scales it by a power of two. The scale is the sum of a 4-bit programmed shift code and a live 3-bit gain-adjust input, clipped at 15. Each gain-adjust step is a left shift by one bit, or 6 dB, so the adjust input adds from 0 dB (000) up to 42 dB (111).

The data word and the gain-adjust value are registered together on the capture edge. The sign-extended, shifted result leaves the block on the next edge in a register wide enough to hold a full shift of 15 without overflow, together with a one-cycle valid flag. When no sample is taken, the output register keeps its last value and the flag stays low.

Top module: `if_gain_front`

## Requirements
- R1: With `cfg_fmt` = 1 the input is two's complement: bit 13 is the sign bit and the word passes through unchanged in value.
- R2: With `cfg_fmt` = 0 the input is offset binary: code 0x0000 means -8192, 0x2000 means 0 and 0x3FFF means +8191. The conversion inverts bit 13.
- R3: A sample is taken on a rising edge exactly when `smp_en_n` is low at that edge. Its result is on `out_data` with `out_vld` high after the following rising edge. `out_vld` is high for one cycle per sample taken, so back-to-back samples give back-to-back results.
- R4: After an edge where no sample is taken, the next edge leaves `out_vld` low and `out_data` unchanged.
- R5: The shift applied is min(`cfg_shift` + `gain_adj`, 15), and the output equals the normalised sample times 2 to the power of that shift.
- R6: `gain_adj` and `cfg_shift` are captured on the same edge as the data word. A change affects only samples taken on that edge or later, never a result already in flight.
- R7: While `rst_n` is low, `out_vld` is 0 and `out_data` is 0.
- R8: `out_data` is a 29-bit signed, sign-extended value. The extreme inputs -8192 and +8191 shifted by 15 come out exact, and the sign of every result matches the sign of its input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fmt | input | 1 | Input format: 1 = two's complement, 0 = offset binary |
| cfg_shift | input | 4 | Programmed shift code |
| gain_adj | input | 3 | Live gain-adjust value, added to the shift code |
| smp_en_n | input | 1 | Active-low sample enable (gated mode) |
| smp_in | input | 14 | Sampled IF word, bit 13 is the MSB |
| out_data | output | 29 | Signed, shifted sample |
| out_vld | output | 1 | High for one cycle when `out_data` holds a new result |

## Verification
Two things can coincide here. A new sample, with a new gain-adjust value, can be captured on the same edge that the previous result appears at the output. The two can also overlap at the clipping boundary, where the summed shift hits or exceeds 15 while the input is at full scale. The bench drives runs of back-to-back samples in which `gain_adj` changes on every edge, mixed with idle gaps and with the extreme codes in both formats. A scoreboard pairs each expected value with the value captured on that sample's own edge and checks it against the result. Any mixing of one sample's gain into its neighbour, any stray or missing valid pulse, and any change to the output during an idle cycle shows up as a mismatch.

// File: rtl/ifg_pkg.sv
package ifg_pkg;

   typedef enum logic {
      FMT_OFFSET = 1'b0,
      FMT_TWOS   = 1'b1
   } ifg_fmt_e;

   // width needed to hold a DATA_W sample left-shifted by the largest code
   function automatic int ifg_out_w(input int data_w, input int shift_w);
      return data_w + (1 << shift_w) - 1;
   endfunction

endpackage

// File: rtl/ifg_fmt_conv.sv
module ifg_fmt_conv #(
   parameter int DATA_W     = 14,
   parameter bit HAS_OFFSET = 1'b1
) (
   input  logic              fmt_sel,
   input  logic [DATA_W-1:0] raw,
   output logic [DATA_W-1:0] conv
);
   import ifg_pkg::*;

   generate
      if (HAS_OFFSET) begin : g_selectable
         logic flip;
         assign flip = (ifg_fmt_e'(fmt_sel) == FMT_OFFSET);
         assign conv = {raw[DATA_W-1] ^ flip, raw[DATA_W-2:0]};
      end else begin : g_twos_only
         logic unused_sel;
         assign unused_sel = fmt_sel;
         assign conv       = raw;
      end
   endgenerate

endmodule

// File: rtl/ifg_shift_sat.sv
module ifg_shift_sat #(
   parameter int SHIFT_W = 4,
   parameter int ADJ_W   = 3
) (
   input  logic [SHIFT_W-1:0] code,
   input  logic [ADJ_W-1:0]   adj,
   output logic [SHIFT_W-1:0] amt
);
   localparam int SUM_W = SHIFT_W + 1;

   generate
      if (ADJ_W > SHIFT_W) begin : g_bad_width
         $error("ifg_shift_sat: ADJ_W must not exceed SHIFT_W");
      end
   endgenerate

   logic [SUM_W-1:0] sum;

   assign sum = {1'b0, code} + {{(SUM_W-ADJ_W){1'b0}}, adj};
   assign amt = sum[SUM_W-1] ? {SHIFT_W{1'b1}} : sum[SHIFT_W-1:0];

endmodule

// File: rtl/ifg_barrel.sv
module ifg_barrel #(
   parameter int DATA_W  = 14,
   parameter int SHIFT_W = 4,
   parameter int OUT_W   = 29
) (
   input  logic [DATA_W-1:0]  din,
   input  logic [SHIFT_W-1:0] amt,
   output logic [OUT_W-1:0]   dout
);
   generate
      if (OUT_W < DATA_W + (1 << SHIFT_W) - 1) begin : g_bad_width
         $error("ifg_barrel: OUT_W too narrow for the largest shift");
      end
   endgenerate

   logic [OUT_W-1:0] stg [0:SHIFT_W];

   assign stg[0] = {{(OUT_W-DATA_W){din[DATA_W-1]}}, din};

   generate
      for (genvar k = 0; k < SHIFT_W; k++) begin : g_stage
         assign stg[k+1] = amt[k] ? (stg[k] << (1 << k)) : stg[k];
      end
   endgenerate

   assign dout = stg[SHIFT_W];

endmodule

// File: rtl/if_gain_front.sv
module if_gain_front #(
   parameter int DATA_W     = 14,
   parameter int SHIFT_W    = 4,
   parameter int ADJ_W      = 3,
   parameter bit HAS_OFFSET = 1'b1,
   parameter int OUT_W      = ifg_pkg::ifg_out_w(DATA_W, SHIFT_W)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_fmt,
   input  logic [SHIFT_W-1:0]       cfg_shift,
   input  logic [ADJ_W-1:0]         gain_adj,
   input  logic                     smp_en_n,
   input  logic [DATA_W-1:0]        smp_in,
   output logic signed [OUT_W-1:0]  out_data,
   output logic                     out_vld
);
   localparam int MAX_SH = (1 << SHIFT_W) - 1;

   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("if_gain_front: DATA_W must be at least 2");
      end
      if (OUT_W < DATA_W + MAX_SH) begin : g_bad_out
         $error("if_gain_front: OUT_W cannot hold the largest shift");
      end
   endgenerate

   logic [DATA_W-1:0]  conv_smp;
   logic [SHIFT_W-1:0] sat_amt;
   logic [DATA_W-1:0]  cap_smp;
   logic [SHIFT_W-1:0] cap_amt;
   logic               cap_vld;
   logic [OUT_W-1:0]   shifted;

   ifg_fmt_conv #(.DATA_W(DATA_W), .HAS_OFFSET(HAS_OFFSET)) u_fmt (
      .fmt_sel (cfg_fmt),
      .raw     (smp_in),
      .conv    (conv_smp)
   );

   ifg_shift_sat #(.SHIFT_W(SHIFT_W), .ADJ_W(ADJ_W)) u_sat (
      .code (cfg_shift),
      .adj  (gain_adj),
      .amt  (sat_amt)
   );

   // capture stage: word and gain are taken on the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_smp <= '0;
         cap_amt <= '0;
         cap_vld <= 1'b0;
      end else begin
         cap_vld <= ~smp_en_n;
         if (!smp_en_n) begin
            cap_smp <= conv_smp;
            cap_amt <= sat_amt;
         end
      end
   end

   ifg_barrel #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W), .OUT_W(OUT_W)) u_sh (
      .din  (cap_smp),
      .amt  (cap_amt),
      .dout (shifted)
   );

   // output stage: update only for a fresh capture, hold otherwise
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_data <= '0;
         out_vld  <= 1'b0;
      end else begin
         out_vld <= cap_vld;
         if (cap_vld) begin
            out_data <= signed'(shifted);
         end
      end
   end

endmodule

// File: rtl/ifg_front_chk.sv
module ifg_front_chk #(
   parameter int DATA_W  = 14,
   parameter int SHIFT_W = 4,
   parameter int ADJ_W   = 3,
   parameter int OUT_W   = 29
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cfg_fmt,
   input logic [SHIFT_W-1:0] cfg_shift,
   input logic [ADJ_W-1:0]   gain_adj,
   input logic               smp_en_n,
   input logic [DATA_W-1:0]  smp_in,
   input logic [OUT_W-1:0]   out_data,
   input logic               out_vld
);
   localparam int MAX_SH = (1 << SHIFT_W) - 1;
   localparam int SUM_W  = SHIFT_W + 1;

   logic [SUM_W-1:0] req_sum;
   assign req_sum = {1'b0, cfg_shift} + {{(SUM_W-ADJ_W){1'b0}}, gain_adj};

   // R3: a taken sample yields a valid result one edge after capture
   a_r3_vld_follows_take: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_en_n |=> ##1 out_vld);

   // R4: no sample taken means no valid result
   a_r4_idle_no_vld: assert property (@(posedge clk) disable iff (!rst_n)
      smp_en_n |=> ##1 !out_vld);

   // R4: output word holds whenever no fresh result is flagged
   a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !out_vld |-> $stable(out_data));

   // R8: result sign equals normalised input sign
   a_r8_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> (out_data[OUT_W-1] ==
                   ($past(smp_in[DATA_W-1], 2) ^ !$past(cfg_fmt, 2))));

   // R5: clipped sum of 15 or more clears the low MAX_SH result bits
   a_r5_sat_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_en_n && (req_sum >= SUM_W'(MAX_SH))) |=> ##1 (out_data[MAX_SH-1:0] == '0));

   // R7: reset state at the outputs
   always @(negedge clk) begin
      if (!rst_n) begin
         a_r7_reset_state: assert (!out_vld && (out_data == '0));
      end
   end

endmodule

bind if_gain_front ifg_front_chk #(
   .DATA_W  (DATA_W),
   .SHIFT_W (SHIFT_W),
   .ADJ_W   (ADJ_W),
   .OUT_W   (OUT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_fmt   (cfg_fmt),
   .cfg_shift (cfg_shift),
   .gain_adj  (gain_adj),
   .smp_en_n  (smp_en_n),
   .smp_in    (smp_in),
   .out_data  (out_data),
   .out_vld   (out_vld)
);

// File: tb/if_gain_front_bench.sv
`timescale 1ns/1ps
module if_gain_front_bench;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               cfg_fmt = 1'b1;
   logic [3:0]         cfg_shift = '0;
   logic [2:0]         gain_adj = '0;
   logic               smp_en_n = 1'b1;
   logic [13:0]        smp_in = '0;
   logic signed [28:0] out_data;
   logic               out_vld;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   typedef struct {
      logic signed [28:0] val;
      string              req;
   } exp_t;

   exp_t sb[$];
   logic signed [28:0] last_seen = '0;

   always #5 clk = ~clk;

   if_gain_front u_if_gain_front (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_fmt   (cfg_fmt),
      .cfg_shift (cfg_shift),
      .gain_adj  (gain_adj),
      .smp_en_n  (smp_en_n),
      .smp_in    (smp_in),
      .out_data  (out_data),
      .out_vld   (out_vld)
   );

   function automatic logic signed [28:0] model(input logic [13:0] s, input bit twos,
                                                input int sh, input int adj);
      logic signed [13:0] v;
      logic signed [28:0] w;
      int e;
      e = sh + adj;
      if (e > 15) e = 15;
      v = {s[13] ^ ~twos, s[12:0]};
      w = v;
      return w <<< e;
   endfunction

   // driver: one call = one clock cycle of stimulus
   task automatic drive(input bit take, input logic [13:0] s, input bit twos,
                        input int sh, input int adj, input string req);
      exp_t it;
      smp_en_n  = ~take;
      smp_in    = s;
      cfg_fmt   = twos;
      cfg_shift = 4'(sh);
      gain_adj  = 3'(adj);
      if (take) begin
         it.val = model(s, twos, sh, adj);
         it.req = req;
         sb.push_back(it);
      end
      @(negedge clk);
   endtask

   // monitor: pops the scoreboard for every valid result, checks holds otherwise
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (out_vld) begin
            exp_t it;
            n_tests++;
            if (sb.size() == 0) begin
               n_fail++;
               $display("FAIL R3 unexpected valid: actual %0d expected no result", out_data);
            end else begin
               it = sb.pop_front();
               if (out_data !== it.val) begin
                  n_fail++;
                  $display("FAIL %s data: actual %0d expected %0d", it.req, out_data, it.val);
               end
            end
            last_seen = out_data;
         end else begin
            n_tests++;
            if (out_data !== last_seen) begin
               n_fail++;
               $display("FAIL R4 hold: actual %0d expected %0d", out_data, last_seen);
            end
         end
      end
   end

   initial begin
      #200000ns;
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R7 reset state
      n_tests++;
      if (out_vld !== 1'b0 || out_data !== '0) begin
         n_fail++;
         $display("FAIL R7 reset: actual vld=%0b data=%0d expected vld=0 data=0", out_vld, out_data);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // R1 two's complement pass-through, no shift
      drive(1, 14'd5,       1, 0, 0, "R1");
      drive(1, 14'h3FFD,    1, 0, 0, "R1");
      drive(1, 14'h1FFF,    1, 0, 0, "R1");
      drive(1, 14'h2000,    1, 0, 0, "R1");
      drive(0, 14'h1234,    1, 0, 0, "R4");
      drive(0, 14'h0001,    1, 7, 7, "R4");

      // R2 offset binary
      drive(1, 14'h0000,    0, 0, 0, "R2");
      drive(1, 14'h3FFF,    0, 0, 0, "R2");
      drive(1, 14'h2000,    0, 0, 0, "R2");
      drive(1, 14'h2005,    0, 1, 0, "R2");

      // R5 shift sum and clipping
      drive(1, 14'd5,       1, 3, 2, "R5");
      drive(1, 14'h3FFF,    1, 8, 7, "R5");
      drive(1, 14'd3,       1, 12, 7, "R5");
      drive(1, 14'd1,       1, 15, 7, "R5");
      drive(1, 14'd1,       1, 14, 1, "R5");
      drive(1, 14'd1,       1, 15, 0, "R5");

      // R8 extremes at full shift, both formats
      drive(1, 14'h2000,    1, 15, 7, "R8");
      drive(1, 14'h1FFF,    1, 15, 0, "R8");
      drive(1, 14'h0000,    0, 9,  6, "R8");
      drive(1, 14'h3FFF,    0, 13, 5, "R8");
      drive(0, 14'h0000,    1, 0, 0, "R4");
      drive(0, 14'h0000,    1, 0, 0, "R4");
      drive(0, 14'h0000,    1, 0, 0, "R4");

      // R6 gain changes on every edge of a back-to-back run
      for (int i = 0; i < 8; i++) begin
         drive(1, 14'(i * 37 + 11), 1, 2, i, "R6");
      end
      // R3 alternating take / idle
      for (int i = 0; i < 6; i++) begin
         drive(i % 2 == 0, 14'(14'h3F00 + i), i % 3 == 0, i, 7 - i, "R3");
      end
      repeat (4) drive(0, 14'h0, 1, 0, 0, "R4");

      // R3 every taken sample produced exactly one result
      n_tests++;
      if (sb.size() != 0) begin
         n_fail++;
         $display("FAIL R3 missing results: actual %0d pending expected 0", sb.size());
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule